// File: doc/BRIEF.md
# Connection Memory with Change Detect

This block is the connection store of a timeslot interchange. It holds 2048 words of 16 bits. An internal playout counter walks through the store in step with the frame, and each word it reaches appears on a registered output bus. A downstream data store decodes that word to pick the source channel and a few per-slot controls. The counter runs in one of two rates. At half rate it advances every second clock, so two clocks make one channel slot. At full rate it advances every clock and wraps from 2047 to 0. A frame pulse restarts the counter at location 0.

A host processor reads and writes any location through an asynchronous strobe-and-acknowledge port. Chip select, strobe and the read/write level are brought into the clock domain through two flip-flop stages. An access state machine then performs the access and drives an active-low acknowledge that stays low until the strobe goes back high.

The block also guards the stored words. A CRC-16 is folded over every word played out in a frame, and the result is compared with the CRC of the previous frame. A mismatch pulls the active-low change flag down. Frames touched by a host write are left out of the comparison, so programming the store never raises the flag. Any host access clears the flag.

Top module: `tsw_conn_mem`

## Requirements
- R1: With `full_rate` low, the playout counter advances on every second clock. Each location is therefore presented on `play_data` for two clocks, starting with location 0 after a frame pulse.
- R2: With `full_rate` high, the playout counter advances on every clock and wraps from location 2047 to location 0 without a frame pulse.
- R3: A clock edge that samples `frame_sync` high clears the playout counter. `play_data` lags the counter by one register. At full rate, the k-th edge after the sync edge shows location k-1. At half rate, it shows location (k-1)/2 (integer division).
- R4: Stored words are played out unchanged, so a downstream decoder sees the layout the host wrote. The layout is: bits 9..0 source channel, bit 10 output enable, bit 11 message enable, bit 12 single/double buffer select, bit 13 external driver enable, bits 15..14 spare. For example, 0x2001 at location 5 appears in slot 5 as source channel 1 with the external driver enabled.
- R5: A host write is requested with `cs_n` low, `ds_n` low and `rd_wr_n` low. It stores `host_wdata` at `host_addr` exactly once. `ack_n` falls between 4 and 9 clocks after the strobe falls.
- R6: A host read is requested with `rd_wr_n` high. `host_rdata` carries the addressed word at least 3 clocks before `ack_n` falls, and `ack_n` falls between 4 and 9 clocks after the strobe falls. `ack_n` stays low while `ds_n` is low and returns high within a few clocks after `ds_n` rises.
- R7: A CRC-16 is computed over the words played out in each frame: polynomial 0x1021, initial value 0xFFFF, word bits taken most significant first. From the third frame pulse after reset onward, a result that differs from the previous frame's result pulls `chg_n` low at the frame-pulse edge. `chg_n` stays low until it is cleared. Identical frames leave it high.
- R8: The start of any host access (`ds_n` low while `cs_n` low) returns `chg_n` high. If a frame-end detection falls in the same clock, the detection wins.
- R9: A frame in which a host write lands is excluded from the comparison, and so is the frame that follows it. Host writes therefore never pull `chg_n` low.
- R10: During reset, `ack_n` and `chg_n` are high, and `play_data` and `host_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_rate | input | 1 | 1: counter advances every clock; 0: every second clock |
| frame_sync | input | 1 | Frame pulse, active high, synchronous counter clear |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| ds_n | input | 1 | Host data strobe, active low, asynchronous |
| rd_wr_n | input | 1 | Host direction: 1 read, 0 write |
| host_addr | input | 11 | Host word address |
| host_wdata | input | 16 | Host write data |
| play_data | output | 16 | Sequentially played control word |
| host_rdata | output | 16 | Host read data |
| ack_n | output | 1 | Transfer acknowledge, active low |
| chg_n | output | 1 | Change detected, active low |

## Verification
A counter or phase fault shows on `play_data` within one or two clocks of a frame pulse, because every slot after the pulse has a known location. A fault in the host state machine shows within about ten clocks of a strobe: the acknowledge falls too early or too late, read data is not ready three clocks ahead of it, or the acknowledge does not release. Corrupted CRC or mute state shows at the next one or two frame pulses. In that case `chg_n` either falls during steady frames or after host writes, or fails to fall when the rate or frame length changes what is played out.

// File: rtl/tsw_cm_pkg.sv
package tsw_cm_pkg;

    localparam int unsigned CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    // Control word layout read by a downstream data store
    typedef struct packed {
        logic [1:0] spare;
        logic       ext_drv_en;
        logic       dbl_buf;
        logic       msg_en;
        logic       out_en;
        logic [9:0] src_chan;
    } cm_word_t;

    typedef enum logic [2:0] {
        HP_IDLE,
        HP_WAIT,
        HP_ACCESS,
        HP_ACK,
        HP_RELEASE
    } hp_state_e;

endpackage

// File: rtl/tsw_cm_ctr.sv
module tsw_cm_ctr #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_rate,
    input  logic              frame_sync,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              take
);

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic              phase;
    } ctr_t;

    ctr_t q, d;

    always_comb begin
        d = q;
        if (frame_sync) begin
            d.cnt   = '0;
            d.phase = 1'b0;
        end else if (full_rate) begin
            d.cnt   = q.cnt + 1'b1;
            d.phase = 1'b0;
        end else begin
            d.phase = ~q.phase;
            if (q.phase) d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr = q.cnt;
    // a word enters the CRC once per slot: first clock of a half-rate pair
    assign take    = full_rate | ~q.phase;

    assert_sync_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (rd_addr == '0));

    assert_full_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rate && !frame_sync) |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    assert_half_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_rate && !frame_sync && !q.phase) |=> $stable(rd_addr));

endmodule

// File: rtl/tsw_cm_host.sv
module tsw_cm_host
    import tsw_cm_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned WAIT_CYC = 1,
    parameter int unsigned RD_HOLD  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rd_wr_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] host_rdata,
    output logic              ack_n,
    output logic              cd_clr
);

    localparam int unsigned MAXC  = (WAIT_CYC > RD_HOLD) ? WAIT_CYC : RD_HOLD;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        hp_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic              is_rd;
        logic              ack_n;
        logic [DATA_W-1:0] rdata;
        logic [2:0]        s1;   // {cs_n, ds_n, rd_wr_n}, first stage
        logic [2:0]        s2;   // second stage
    } hp_t;

    hp_t  q, d;
    logic cs_s, ds_s, rw_s;

    assign cs_s = q.s2[2];
    assign ds_s = q.s2[1];
    assign rw_s = q.s2[0];

    always_comb begin
        d      = q;
        d.s1   = {cs_n, ds_n, rd_wr_n};
        d.s2   = q.s1;
        mem_we = 1'b0;
        cd_clr = 1'b0;
        case (q.st)
            HP_IDLE: begin
                if (!cs_s && !ds_s) begin
                    d.st    = HP_WAIT;
                    d.cnt   = '0;
                    d.is_rd = rw_s;
                    cd_clr  = 1'b1;
                end
            end
            HP_WAIT: begin
                if (q.cnt == CNT_W'(WAIT_CYC - 1)) begin
                    d.st  = HP_ACCESS;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            HP_ACCESS: begin
                if (q.cnt == '0) begin
                    if (q.is_rd) d.rdata = mem_rdata;
                    else         mem_we  = 1'b1;
                end
                if (!q.is_rd || q.cnt == CNT_W'(RD_HOLD)) begin
                    d.st    = HP_ACK;
                    d.ack_n = 1'b0;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            HP_ACK: begin
                if (ds_s) begin
                    d.st    = HP_RELEASE;
                    d.ack_n = 1'b1;
                end
            end
            HP_RELEASE: d.st = HP_IDLE;
            default:    d.st = HP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: HP_IDLE, cnt: '0, is_rd: 1'b0, ack_n: 1'b1,
                   rdata: '0, s1: 3'b111, s2: 3'b111};
        end else begin
            q <= d;
        end
    end

    assign host_rdata = q.rdata;
    assign ack_n      = q.ack_n;

    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ack_n && !ds_s) |=> !q.ack_n);

    assert_rdata_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ack_n |=> $stable(q.rdata));

    assert_ack_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ack_n) |-> $past(q.st == HP_ACCESS));

endmodule

// File: rtl/tsw_cm_crc.sv
module tsw_cm_crc
    import tsw_cm_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              take,
    input  logic [DATA_W-1:0] word,
    input  logic              host_wr,
    input  logic              cd_clr,
    output logic              chg
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] prev;
        logic             seen_sync;
        logic             prev_ok;
        logic             wr_seen;
        logic             skip_next;
        logic             cd;
    } crc_t;

    crc_t             q, d;
    logic [CRC_W-1:0] step;
    logic [CRC_W-1:0] acc;
    logic             wr_any;
    logic             mute;

    always_comb begin
        step = q.crc;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (step[CRC_W-1] ^ word[i]) step = {step[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else                         step = {step[CRC_W-2:0], 1'b0};
        end
        acc = take ? step : q.crc;
    end

    always_comb begin
        d      = q;
        wr_any = q.wr_seen | host_wr;
        mute   = wr_any | q.skip_next | ~q.prev_ok;
        if (frame_sync) begin
            if (!mute && acc != q.prev) d.cd = 1'b1;
            else if (cd_clr)            d.cd = 1'b0;
            d.prev      = acc;
            d.prev_ok   = q.seen_sync;
            d.seen_sync = 1'b1;
            d.crc       = CRC_INIT;
            d.skip_next = wr_any;
            d.wr_seen   = 1'b0;
        end else begin
            d.crc     = acc;
            d.wr_seen = wr_any;
            if (cd_clr) d.cd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.crc <= CRC_INIT;
        end else begin
            q <= d;
        end
    end

    assign chg = q.cd;

    assert_set_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cd) |-> $past(frame_sync));

    assert_clear_on_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_clr && !frame_sync) |=> !q.cd);

    assert_write_mutes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && (host_wr || q.wr_seen || q.skip_next)) |=> !$rose(q.cd));

endmodule

// File: rtl/tsw_conn_mem.sv
module tsw_conn_mem #(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned WAIT_CYC = 1,
    parameter int unsigned RD_HOLD  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_rate,
    input  logic              frame_sync,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] play_data,
    output logic [DATA_W-1:0] host_rdata,
    output logic              ack_n,
    output logic              chg_n
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] p_addr;
    logic              take;
    logic              mem_we;
    logic              cd_clr;
    logic              chg;
    logic [DATA_W-1:0] p_word;
    logic [DATA_W-1:0] h_word;
    logic [DATA_W-1:0] play_d, play_q;

    tsw_cm_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_rate  (full_rate),
        .frame_sync (frame_sync),
        .rd_addr    (p_addr),
        .take       (take)
    );

    tsw_cm_host #(.DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC), .RD_HOLD(RD_HOLD)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .ds_n       (ds_n),
        .rd_wr_n    (rd_wr_n),
        .mem_rdata  (h_word),
        .mem_we     (mem_we),
        .host_rdata (host_rdata),
        .ack_n      (ack_n),
        .cd_clr     (cd_clr)
    );

    tsw_cm_crc #(.DATA_W(DATA_W)) u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .take       (take),
        .word       (p_word),
        .host_wr    (mem_we),
        .cd_clr     (cd_clr),
        .chg        (chg)
    );

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[host_addr] <= host_wdata;
    end

    assign p_word = mem_q[p_addr];
    assign h_word = mem_q[host_addr];

    always_comb play_d = p_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) play_q <= '0;
        else        play_q <= play_d;
    end

    assign play_data = play_q;
    assign chg_n     = ~chg;

    assert_chg_quiet_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !frame_sync) |=> !$fell(chg_n));

endmodule

// File: tb/tsw_conn_mem_bench.sv
`timescale 1ns/1ps
module tsw_conn_mem_bench;
    import tsw_cm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        full_rate;
    logic        frame_sync;
    logic        cs_n, ds_n, rd_wr_n;
    logic [10:0] host_addr;
    logic [15:0] host_wdata;
    logic [15:0] play_data, host_rdata;
    logic        ack_n, chg_n;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int frame_len = 40;
    bit fs_run    = 0;
    int fcnt      = 0;

    logic [15:0] model [2048];
    logic [15:0] exp_q [$];
    bit          cur_rd = 0;

    always #2.5 clk = ~clk;

    tsw_conn_mem u_tsw_conn_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_rate  (full_rate),
        .frame_sync (frame_sync),
        .cs_n       (cs_n),
        .ds_n       (ds_n),
        .rd_wr_n    (rd_wr_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .play_data  (play_data),
        .host_rdata (host_rdata),
        .ack_n      (ack_n),
        .chg_n      (chg_n)
    );

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // frame pulse generator, driven on the falling edge
    initial begin
        frame_sync = 1'b0;
        forever begin
            @(negedge clk);
            if (!fs_run) begin
                fcnt = 0;
                frame_sync = 1'b0;
            end else begin
                fcnt = (fcnt >= frame_len - 1) ? 0 : fcnt + 1;
                frame_sync = (fcnt == 0);
            end
        end
    end

    // scoreboard monitor: pops the expected read word at each acknowledge
    initial begin
        logic [15:0] h1, h2, h3, e;
        logic        ack_prev;
        h1 = '0; h2 = '0; h3 = '0; ack_prev = 1'b1;
        forever begin
            @(negedge clk);
            if (ack_prev && !ack_n && cur_rd) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 read with no expectation", host_rdata, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(host_rdata == e, "R6 read data", host_rdata, e);
                    check(h3 == e, "R6 data valid 3 clocks before ack", h3, e);
                end
            end
            h3 = h2; h2 = h1; h1 = host_rdata; ack_prev = ack_n;
        end
    end

    task automatic host_access(input bit rd, input logic [10:0] a, input logic [15:0] dv);
        int lat;
        @(negedge clk);
        cur_rd = rd;
        if (rd) exp_q.push_back(model[a]);
        else    model[a] = dv;
        cs_n = 1'b0; rd_wr_n = rd; host_addr = a; host_wdata = dv; ds_n = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (ack_n && lat < 40);
        if (rd) check(lat >= 4 && lat <= 9, "R6 read ack latency", lat, 8);
        else    check(lat >= 4 && lat <= 9, "R5 write ack latency", lat, 5);
        repeat (3) @(negedge clk);
        check(ack_n == 1'b0, "R6 ack held while strobe low", ack_n, 0);
        ds_n = 1'b1;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!ack_n && lat < 40);
        check(lat >= 2 && lat <= 5, "R6 ack release after strobe rise", lat, 3);
        cs_n = 1'b1; rd_wr_n = 1'b1;
    endtask

    task automatic wait_sync();
        @(posedge clk);
        while (!frame_sync) @(posedge clk);
        #1;
    endtask

    task automatic wait_frames(input int n);
        repeat (n) wait_sync();
    endtask

    // call right after wait_sync: edge E0 has just passed
    task automatic check_play(input bit full, input int k0, input int k1);
        for (int k = 1; k <= k1; k++) begin
            @(posedge clk); #1;
            if (k >= k0) begin
                int idx;
                logic [15:0] ev;
                cm_word_t w;
                idx = (full ? (k - 1) : ((k - 1) / 2)) % 2048;
                ev  = model[idx];
                if (k == 1)    check(play_data == ev, "R3 first slot after sync", play_data, ev);
                else if (full) check(play_data == ev, "R2 full-rate playout", play_data, ev);
                else           check(play_data == ev, "R1 half-rate playout", play_data, ev);
                if (full && k == 6) begin
                    w = cm_word_t'(play_data);
                    check(w.src_chan == 10'd1 && w.ext_drv_en && !w.out_en && !w.msg_en
                          && !w.dbl_buf, "R4 slot 5 word decode", play_data, 16'h2001);
                end
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; ds_n = 1'b1; rd_wr_n = 1'b1;
        host_addr = '0; host_wdata = '0; full_rate = 1'b1;
        for (int i = 0; i < 2048; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        check(ack_n == 1'b1, "R10 reset ack_n", ack_n, 1);
        check(chg_n == 1'b1, "R10 reset chg_n", chg_n, 1);
        check(play_data == 16'h0, "R10 reset play_data", play_data, 0);
        check(host_rdata == 16'h0, "R10 reset host_rdata", host_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1; fs_run = 1;

        // program the store, then read parts back
        for (int i = 0; i < 32; i++)
            host_access(1'b0, 11'(i), (i == 5) ? 16'h2001 : 16'(16'h0A00 + i * 37));
        host_access(1'b0, 11'd2047, 16'h7FF7);
        for (int i = 0; i < 8; i++) host_access(1'b1, 11'(i), 16'h0);
        host_access(1'b1, 11'd2047, 16'h0);

        wait_frames(4);
        check(chg_n == 1'b1, "R9 writes leave chg_n high", chg_n, 1);

        wait_sync();
        check_play(1'b1, 1, 16);

        // switch to half rate: played contents change, flag must fall
        wait_sync();
        full_rate = 1'b0;
        wait_sync();
        check_play(1'b0, 1, 16);
        wait_sync();
        check(chg_n == 1'b0, "R7 change after rate switch", chg_n, 0);
        host_access(1'b1, 11'd3, 16'h0);
        check(chg_n == 1'b1, "R8 access clears chg_n", chg_n, 1);
        wait_frames(3);
        check(chg_n == 1'b1, "R7 steady frames keep chg_n high", chg_n, 1);

        // long full-rate frame: wrap at 2047
        wait_sync();
        full_rate = 1'b1;
        frame_len = 2100;
        check_play(1'b1, 2048, 2049);
        wait_sync();
        frame_len = 40;
        wait_frames(3);
        check(chg_n == 1'b0, "R7 change after frame length change", chg_n, 0);

        // a write both clears the flag and is muted itself
        host_access(1'b0, 11'd10, 16'h3C3C);
        check(chg_n == 1'b1, "R8 write access clears chg_n", chg_n, 1);
        wait_frames(4);
        check(chg_n == 1'b1, "R9 content write not flagged", chg_n, 1);
        host_access(1'b1, 11'd10, 16'h0);
        host_access(1'b1, 11'd5, 16'h0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule